// File: doc/BRIEF.md
# Real-Time Clock Interrupt Source Generator

This block produces the interrupt causes of a real-time clock. A free-running divider counts strobes from a 32.768 kHz timebase. A 4-bit rate code selects one of its taps, from a 2 Hz period down to 122 µs. Each time the selected tap completes, the periodic flag is set. The same tap, at half its period, drives a square-wave output.

The calendar logic outside the block pulses an update-done strobe at the end of each time update. That strobe sets the update-ended flag. It also compares the current hours, minutes and seconds against three alarm bytes. An alarm byte whose two top bits are both 1 matches any value of its field, so the alarm can fire once per second, minute, hour or day.

The three flags set whether or not they are enabled. One active-low interrupt line is asserted while any flag is set together with its enable. A read strobe from the register interface clears all three flags at once.

Top module: `rtc_irq_gen`

## Requirements
- R1: While rst_n is low and in the first cycle after reset, flag_per, flag_alm and flag_upd are 0, irq_n is 1 and sqw is 0.
- R2: The rate code maps to an exponent e as follows: code 0 means off, code 1 gives e = 7, code 2 gives e = 8, and codes 3 to 15 give e = code - 1. flag_per becomes 1 in the cycle after the tick_32k strobe whose count since reset is a multiple of 2^e. With code 0 it never sets.
- R3: On an upd_done strobe, flag_alm becomes 1 in the next cycle when each of the three fields matches. A field matches when its alarm byte equals the current byte, or when the alarm byte has bits 7 and 6 both set. With any field not matching, the strobe leaves flag_alm unchanged.
- R4: An upd_done strobe sets flag_upd in the next cycle.
- R5: Flags set regardless of per_en, alm_en and upd_en. irq_n is 0 exactly when some flag is 1 together with its enable.
- R6: A flag_rd strobe clears all three flags in the next cycle, which releases irq_n. An event arriving in the same cycle as the read still sets its flag.
- R7: With sqw_en at 1 and a nonzero rate code, sqw toggles after each tick whose count since reset is a multiple of 2^(e-1). Otherwise sqw is 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle strobe per 32.768 kHz period |
| rate_sel | input | 4 | Periodic rate code |
| per_en | input | 1 | Periodic interrupt enable |
| alm_en | input | 1 | Alarm interrupt enable |
| upd_en | input | 1 | Update-ended interrupt enable |
| sqw_en | input | 1 | Square-wave output enable |
| upd_done | input | 1 | End-of-update strobe from the calendar |
| flag_rd | input | 1 | Flag register read strobe |
| cur_sec | input | 8 | Current seconds |
| cur_min | input | 8 | Current minutes |
| cur_hr | input | 8 | Current hours |
| alm_sec | input | 8 | Alarm seconds (0xC0-0xFF is don't-care) |
| alm_min | input | 8 | Alarm minutes (0xC0-0xFF is don't-care) |
| alm_hr | input | 8 | Alarm hours (0xC0-0xFF is don't-care) |
| flag_per | output | 1 | Periodic flag |
| flag_alm | output | 1 | Alarm flag |
| flag_upd | output | 1 | Update-ended flag |
| irq_n | output | 1 | Active-low interrupt request |
| sqw | output | 1 | Square-wave output |

## Verification
The assertions assume that tick_32k, upd_done and flag_rd are single-cycle strobes sampled at the clock edge. They also assume that the time and alarm bytes are stable in the cycle an update-done strobe is sampled. The stimulus changes every input only at the falling clock edge and raises each strobe for exactly one cycle. It alters the time and alarm bytes only between strobes. Ticks arrive every second cycle, which stands in for the slow timebase and keeps the long 2 Hz period within reach.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int RATE_W = 4;
    localparam int EXP_W  = 5;

    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } irq_flags_t;

    // Divider exponent for a rate code; 0 means periodic source off.
    function automatic logic [EXP_W-1:0] rate_exp(input logic [RATE_W-1:0] code);
        logic [EXP_W-1:0] e;
        case (code)
            4'd0:    e = '0;
            4'd1:    e = EXP_W'(7);
            4'd2:    e = EXP_W'(8);
            default: e = EXP_W'(code) - EXP_W'(1);
        endcase
        return e;
    endfunction

endpackage

// File: rtl/rtc_rate_div.sv
module rtc_rate_div
    import rtc_irq_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              sqw_en,
    output logic              per_evt,
    output logic              sqw
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             wave;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [EXP_W-1:0] exp_s;
    logic [DIV_W-1:0] full_mask, half_mask;
    logic             half_evt;

    // Thermometer masks of e and e-1 low bits.
    for (genvar i = 0; i < DIV_W; i++) begin : g_mask
        assign full_mask[i] = (EXP_W'(i) < exp_s);
        assign half_mask[i] = (EXP_W'(i + 1) < exp_s);
    end

    always_comb begin
        exp_s    = rate_exp(rate_sel);
        per_evt  = tick && (exp_s != '0) && ((st_q.cnt & full_mask) == full_mask);
        half_evt = tick && (exp_s != '0) && ((st_q.cnt & half_mask) == half_mask);
        st_d     = st_q;
        if (tick) begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
        if (!sqw_en || exp_s == '0) begin
            st_d.wave = 1'b0;
        end else if (half_evt) begin
            st_d.wave = ~st_q.wave;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sqw = st_q.wave;

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int FIELDS = 3,
    parameter int FW     = 8
) (
    input  logic [FIELDS-1:0][FW-1:0] cur_t,
    input  logic [FIELDS-1:0][FW-1:0] alm_t,
    output logic                      hit
);

    logic [FIELDS-1:0] field_ok;

    for (genvar f = 0; f < FIELDS; f++) begin : g_field
        logic wild;
        assign wild        = &alm_t[f][FW-1:FW-2];
        assign field_ok[f] = wild || (alm_t[f] == cur_t[f]);
    end

    assign hit = &field_ok;

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  irq_flags_t set_i,
    input  irq_flags_t en_i,
    input  logic       clr_i,
    output irq_flags_t flags_o,
    output logic       irq_n
);

    irq_flags_t fl_d, fl_q;

    always_comb begin
        fl_d = clr_i ? '0 : fl_q;
        fl_d = fl_d | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags_o = fl_q;
    assign irq_n   = ~|(fl_q & en_i);

endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen
    import rtc_irq_pkg::*;
#(
    parameter int DIV_W = 15,
    parameter int FW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              per_en,
    input  logic              alm_en,
    input  logic              upd_en,
    input  logic              sqw_en,
    input  logic              upd_done,
    input  logic              flag_rd,
    input  logic [FW-1:0]     cur_sec,
    input  logic [FW-1:0]     cur_min,
    input  logic [FW-1:0]     cur_hr,
    input  logic [FW-1:0]     alm_sec,
    input  logic [FW-1:0]     alm_min,
    input  logic [FW-1:0]     alm_hr,
    output logic              flag_per,
    output logic              flag_alm,
    output logic              flag_upd,
    output logic              irq_n,
    output logic              sqw
);

    localparam int FIELDS = 3;

    logic                      per_evt, alm_hit;
    logic [FIELDS-1:0][FW-1:0] cur_t, alm_t;
    irq_flags_t                set_s, en_s, flags_s;

    assign cur_t = {cur_hr, cur_min, cur_sec};
    assign alm_t = {alm_hr, alm_min, alm_sec};

    rtc_rate_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_32k),
        .rate_sel (rate_sel),
        .sqw_en   (sqw_en),
        .per_evt  (per_evt),
        .sqw      (sqw)
    );

    rtc_alarm_cmp #(.FIELDS(FIELDS), .FW(FW)) u_alm (
        .cur_t (cur_t),
        .alm_t (alm_t),
        .hit   (alm_hit)
    );

    always_comb begin
        set_s.per = per_evt;
        set_s.alm = upd_done && alm_hit;
        set_s.upd = upd_done;
        en_s.per  = per_en;
        en_s.alm  = alm_en;
        en_s.upd  = upd_en;
    end

    rtc_irq_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_s),
        .en_i    (en_s),
        .clr_i   (flag_rd),
        .flags_o (flags_s),
        .irq_n   (irq_n)
    );

    assign flag_per = flags_s.per;
    assign flag_alm = flags_s.alm;
    assign flag_upd = flags_s.upd;

endmodule

// File: rtl/rtc_irq_gen_chk.sv
module rtc_irq_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_32k,
    input logic [3:0] rate_sel,
    input logic       per_en,
    input logic       alm_en,
    input logic       upd_en,
    input logic       sqw_en,
    input logic       upd_done,
    input logic       flag_rd,
    input logic       flag_per,
    input logic       flag_alm,
    input logic       flag_upd,
    input logic       irq_n,
    input logic       sqw
);

    // R2: code 0 never raises the periodic flag
    a_r2_off_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 4'd0 && !flag_per) |=> !flag_per);

    // R4: update strobe always sets its flag
    a_r4_upd_sets: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> flag_upd);

    // R5: an enabled pending flag pulls the line low
    a_r5_irq_asserted: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_per && per_en) || (flag_alm && alm_en) || (flag_upd && upd_en)) |-> !irq_n);

    // R5: a low line needs an enabled pending flag
    a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((flag_per && per_en) || (flag_alm && alm_en) || (flag_upd && upd_en)));

    // R6: read with no coinciding event empties the flags
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !tick_32k && !upd_done) |=> (!flag_per && !flag_alm && !flag_upd));

    // R7: disabled square wave goes low
    a_r7_sqw_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!sqw_en || rate_sel == 4'd0) |=> !sqw);

    // R7: square wave only moves on a tick
    a_r7_sqw_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_32k && sqw_en && rate_sel != 4'd0) |=> $stable(sqw));

endmodule

bind rtc_irq_gen rtc_irq_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_32k (tick_32k),
    .rate_sel (rate_sel),
    .per_en   (per_en),
    .alm_en   (alm_en),
    .upd_en   (upd_en),
    .sqw_en   (sqw_en),
    .upd_done (upd_done),
    .flag_rd  (flag_rd),
    .flag_per (flag_per),
    .flag_alm (flag_alm),
    .flag_upd (flag_upd),
    .irq_n    (irq_n),
    .sqw      (sqw)
);

// File: tb/rtc_irq_gen_test.sv
module rtc_irq_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       per_en = 1'b0, alm_en = 1'b0, upd_en = 1'b0, sqw_en = 1'b0;
    logic       upd_done = 1'b0, flag_rd = 1'b0;
    logic [7:0] cur_sec = 8'd0, cur_min = 8'd0, cur_hr = 8'd0;
    logic [7:0] alm_sec = 8'd0, alm_min = 8'd0, alm_hr = 8'd0;
    logic       flag_per, flag_alm, flag_upd, irq_n, sqw;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit tick_run = 1'b0;
    bit tick_phase = 1'b0;
    bit done = 1'b0;

    // Reference model state
    int  m_ticks = 0;
    bit  m_per = 0, m_alm = 0, m_upd = 0, m_sqw = 0;

    always #10 clk = ~clk;

    rtc_irq_gen uut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_sel(rate_sel),
        .per_en(per_en), .alm_en(alm_en), .upd_en(upd_en), .sqw_en(sqw_en),
        .upd_done(upd_done), .flag_rd(flag_rd),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
        .flag_per(flag_per), .flag_alm(flag_alm), .flag_upd(flag_upd),
        .irq_n(irq_n), .sqw(sqw)
    );

    function automatic int exp_of(input logic [3:0] code);
        if (code == 4'd0) return 0;
        if (code == 4'd1) return 7;
        if (code == 4'd2) return 8;
        return int'(code) - 1;
    endfunction

    function automatic bit fmatch(input logic [7:0] a, input logic [7:0] c);
        return (a[7:6] == 2'b11) || (a == c);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ticks = 0; m_per = 0; m_alm = 0; m_upd = 0; m_sqw = 0;
        end else begin
            int  e;
            bit  s_per, s_alm;
            e = exp_of(rate_sel);
            s_per = 0;
            if (tick_32k) m_ticks++;
            if (tick_32k && e != 0 && (m_ticks % (1 << e)) == 0) s_per = 1;
            s_alm = upd_done && fmatch(alm_sec, cur_sec) && fmatch(alm_min, cur_min)
                    && fmatch(alm_hr, cur_hr);
            if (flag_rd) begin m_per = 0; m_alm = 0; m_upd = 0; end
            m_per = m_per | s_per;
            m_alm = m_alm | s_alm;
            m_upd = m_upd | upd_done;
            if (!sqw_en || e == 0) m_sqw = 0;
            else if (tick_32k && (m_ticks % (1 << (e - 1))) == 0) m_sqw = ~m_sqw;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic compare();
        check("R2/R6 flag_per", flag_per, m_per);
        check("R3/R6 flag_alm", flag_alm, m_alm);
        check("R4/R6 flag_upd", flag_upd, m_upd);
        check("R5 irq_n", irq_n,
              !((m_per && per_en) || (m_alm && alm_en) || (m_upd && upd_en)));
        check("R7 sqw", sqw, m_sqw);
    endtask

    task automatic step();
        @(negedge clk);
        if (rst_n) compare();
        tick_32k = tick_run && tick_phase;
        tick_phase = ~tick_phase;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pulse_rd();
        flag_rd = 1'b1; step(); flag_rd = 1'b0;
    endtask

    task automatic pulse_upd();
        upd_done = 1'b1; step(); upd_done = 1'b0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset flag_per", flag_per, 1'b0);
        check("R1 reset flag_alm", flag_alm, 1'b0);
        check("R1 reset flag_upd", flag_upd, 1'b0);
        check("R1 reset irq_n", irq_n, 1'b1);
        check("R1 reset sqw", sqw, 1'b0);
        rst_n = 1'b1;
        step();
        check("R1 after reset irq_n", irq_n, 1'b1);

        // R2 and R7: fastest rate, square wave on
        rate_sel = 4'd3; per_en = 1'b1; sqw_en = 1'b1; tick_run = 1'b1;
        run(40);
        check("R2 flag_per set at code 3", flag_per, 1'b1);
        check("R5 irq_n low with per_en", irq_n, 1'b0);
        pulse_rd();
        for (int k = 0; k < 6; k++) begin run(17); pulse_rd(); end

        // R2: codes 1 and 6
        rate_sel = 4'd1; run(600); pulse_rd(); run(300);
        rate_sel = 4'd6; run(400); pulse_rd(); run(200);

        // R2 and R7: code 0 disables both
        rate_sel = 4'd0; pulse_rd(); run(500);
        check("R2 code 0 no flag_per", flag_per, 1'b0);
        check("R7 sqw low at code 0", sqw, 1'b0);
        rate_sel = 4'd4; sqw_en = 1'b0; run(100);
        check("R7 sqw low when disabled", sqw, 1'b0);
        sqw_en = 1'b1; tick_run = 1'b0; pulse_rd(); run(4);

        // R3: alarm matching
        alm_en = 1'b1;
        cur_hr = 8'h12; cur_min = 8'h34; cur_sec = 8'h56;
        alm_hr = 8'h12; alm_min = 8'h34; alm_sec = 8'h57;
        pulse_upd(); step();
        check("R3 mismatch leaves flag_alm", flag_alm, 1'b0);
        check("R4 flag_upd set", flag_upd, 1'b1);
        pulse_rd(); step();
        alm_sec = 8'h56; pulse_upd(); step();
        check("R3 exact match", flag_alm, 1'b1);
        pulse_rd(); step();
        check("R6 read cleared flag_alm", flag_alm, 1'b0);
        check("R6 read released irq_n", irq_n, 1'b1);
        alm_hr = 8'hC0; alm_min = 8'hFF; alm_sec = 8'hC3; cur_hr = 8'h05;
        pulse_upd(); step();
        check("R3 all don't-care match", flag_alm, 1'b1);
        pulse_rd();
        alm_hr = 8'h80; pulse_upd(); step();
        check("R3 bit7 only is not don't-care", flag_alm, 1'b0);
        pulse_rd();

        // R6: read and update in the same cycle, update wins
        alm_hr = 8'hFF;
        pulse_upd(); step();
        flag_rd = 1'b1; upd_done = 1'b1; step();
        flag_rd = 1'b0; upd_done = 1'b0; step();
        check("R6 coinciding update kept flag_upd", flag_upd, 1'b1);
        pulse_rd(); step();

        // R5: flags set with enables off, irq stays high
        per_en = 1'b0; alm_en = 1'b0; upd_en = 1'b0;
        pulse_upd(); step();
        check("R5 flag_upd set while disabled", flag_upd, 1'b1);
        check("R5 irq_n high while disabled", irq_n, 1'b1);
        upd_en = 1'b1; step();
        check("R5 irq_n low after enable", irq_n, 1'b0);
        pulse_rd(); step();

        // R2: slowest rate, reaching the 2^14 tick boundary
        rate_sel = 4'd15; tick_run = 1'b1; per_en = 1'b1;
        run(70000);
        check("R2 flag_per at code 15", flag_per, 1'b1);
        pulse_rd(); run(20);

        report();
    end

endmodule